// File: doc/BRIEF.md
# Period-Synchronous PWM Gate Controller

This block drives the gate of one external switch with a pulse-width modulated waveform. Each period is divided into 100 equal slots. The output is high for as many leading slots as the active duty value, so one duty count equals one percent.

A 3-bit frequency code selects the slot length. One slot lasts `SLOT_UNIT << code` base-clock cycles, so one period lasts `100 * (SLOT_UNIT << code)` cycles. As an example, a 1.28 MHz base clock with `SLOT_UNIT = 10` gives 10 Hz at code 7 and 1280 Hz at code 0.

Duty and frequency can be written at any time. A write lands in shadow storage and takes effect only at the next period start. The on/off request is the OR of a parallel pin and a serial bit. It is also sampled only at a period start, so the output never changes partway through a period.

A short-fault supervisor can pulse `fault_trip`. This forces the output off for an inhibit window of `INHIBIT_LEN` cycles, which the integrator sets to 100 times the fault time. After the window, the output waits for the next period start before it resumes.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: With an active duty value D between 1 and 100, each period drives `gate_out` high for exactly `D * (SLOT_UNIT << code)` cycles, starting at the period start.
- R2: Duty values 101 to 127 are clamped to 100, so the output stays high for the whole period.
- R3: A duty value of 0 keeps `gate_out` low for the whole period.
- R4: One period lasts `100 * (SLOT_UNIT << code)` base-clock cycles. The code is 3 bits, and code 0 is the shortest period.
- R5: A write strobe `wr_en` captures `duty_in` (7 bits) and `freq_code`. The period in progress keeps its duty and length, and the new values take effect at the next period start.
- R6: The run request is `run_pin OR run_ser`. It is sampled only at a period start, so a high pulse that has begun always completes, and a new pulse can begin only at slot 0.
- R7: While `mode_en` is low, `gate_out` is low from the next clock edge onward and the period timer is cleared. On the cycle `mode_en` is first seen high, a new period starts, and the output can go high on the following edge.
- R8: A `fault_trip` pulse drives `gate_out` low by the second clock edge and holds it low for at least `INHIBIT_LEN` cycles. A second trip during the window restarts the window.
- R9: When the inhibit window has expired, the output resumes only at the next period start, never partway through a period.
- R10: Synchronous active-high reset clears `gate_out`, the shadow and active settings, the period timer and the fault hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables the PWM engine; when low, the output is off and the timer is cleared |
| wr_en | input | 1 | One-cycle strobe that stages `duty_in` and `freq_code` |
| duty_in | input | 7 | Duty count, one percent per count; values above 100 clamp to 100 |
| freq_code | input | 3 | Selects a slot length of `SLOT_UNIT << freq_code` cycles |
| run_pin | input | 1 | Parallel on/off request |
| run_ser | input | 1 | Serial on/off request bit, ORed with `run_pin` |
| fault_trip | input | 1 | Pulse from the short-fault supervisor that starts an inhibit window |
| gate_out | output | 1 | Registered gate drive |

## Verification
The checker tests the following on every cycle:
- the active duty never exceeds 100 and the slot index stays below 100;
- the active duty only changes at a period start;
- a zero duty, a cleared enable or a running inhibit window forces the output low;
- every rising output edge comes from slot 0;
- the fault hold releases only at a period start.

Some behaviour can only be shown by the bench's scenarios, because it depends on pulse widths and waveform phase:
- exact high and low widths for each duty and code;
- a write in mid-period leaving the current pulse unchanged;
- a request that drops mid-pulse still completing the pulse;
- the resume after a fault landing on the period grid that ran before the fault.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int DUTY_W = 7;
  localparam int CODE_W = 3;
  localparam int SLOTS  = 100;
  localparam int IDX_W  = $clog2(SLOTS);

  // Clamp a duty count to the slot count (full-on).
  function automatic logic [DUTY_W-1:0] clamp_duty(input logic [DUTY_W-1:0] d);
    return (d > DUTY_W'(SLOTS)) ? DUTY_W'(SLOTS) : d;
  endfunction
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwm_gate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic [LEN_W-1:0] slot_len,
  output logic [IDX_W-1:0] slot_idx,
  output logic             started,
  output logic             period_start
);
  logic [LEN_W-1:0] tick_cnt;
  logic             slot_end;

  always_comb begin
    slot_end     = (tick_cnt == slot_len - LEN_W'(1));
    period_start = mode_en && (!started || (slot_end && slot_idx == IDX_W'(SLOTS - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !mode_en) begin
      tick_cnt <= '0;
      slot_idx <= '0;
      started  <= 1'b0;
    end else if (period_start) begin
      tick_cnt <= '0;
      slot_idx <= '0;
      started  <= 1'b1;
    end else if (slot_end) begin
      tick_cnt <= '0;
      slot_idx <= slot_idx + IDX_W'(1);
    end else begin
      tick_cnt <= tick_cnt + LEN_W'(1);
    end
  end
endmodule

// File: rtl/pwm_setting_stage.sv
module pwm_setting_stage
  import pwm_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [CODE_W-1:0] freq_code,
  input  logic              run_req,
  input  logic              period_start,
  output logic [DUTY_W-1:0] act_duty,
  output logic [CODE_W-1:0] act_code,
  output logic              act_run
);
  logic [DUTY_W-1:0] sh_duty;
  logic [CODE_W-1:0] sh_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_duty  <= '0;
      sh_code  <= '0;
      act_duty <= '0;
      act_code <= '0;
      act_run  <= 1'b0;
    end else begin
      if (wr_en) begin
        sh_duty <= duty_in;
        sh_code <= freq_code;
      end
      if (period_start) begin
        act_duty <= clamp_duty(wr_en ? duty_in : sh_duty);
        act_code <= wr_en ? freq_code : sh_code;
        act_run  <= run_req;
      end
    end
  end
endmodule

// File: rtl/pwm_fault_hold.sv
module pwm_fault_hold #(
  parameter int INHIBIT_LEN = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_trip,
  input  logic period_start,
  output logic blk,
  output logic inh_busy
);
  localparam int INH_W = $clog2(INHIBIT_LEN + 1);

  logic [INH_W-1:0] inh_cnt;

  always_comb inh_busy = (inh_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_cnt <= '0;
      blk     <= 1'b0;
    end else if (fault_trip) begin
      inh_cnt <= INH_W'(INHIBIT_LEN);
      blk     <= 1'b1;
    end else begin
      if (inh_busy) inh_cnt <= inh_cnt - INH_W'(1);
      if (period_start && !inh_busy) blk <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int SLOT_UNIT   = 10,
  parameter int INHIBIT_LEN = 1200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              wr_en,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [CODE_W-1:0] freq_code,
  input  logic              run_pin,
  input  logic              run_ser,
  input  logic              fault_trip,
  output logic              gate_out
);
  localparam int MAX_LEN = SLOT_UNIT * (2 ** ((2 ** CODE_W) - 1));
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [DUTY_W-1:0] act_duty;
  logic [CODE_W-1:0] act_code;
  logic              act_run;
  logic [IDX_W-1:0]  slot_idx;
  logic              started;
  logic              period_start;
  logic              blk;
  logic              inh_busy;
  logic [LEN_W-1:0]  slot_len;

  always_comb slot_len = LEN_W'(SLOT_UNIT) << act_code;

  pwm_period_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .mode_en(mode_en), .slot_len(slot_len),
    .slot_idx(slot_idx), .started(started), .period_start(period_start)
  );

  pwm_setting_stage u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .duty_in(duty_in),
    .freq_code(freq_code), .run_req(run_pin | run_ser),
    .period_start(period_start), .act_duty(act_duty),
    .act_code(act_code), .act_run(act_run)
  );

  pwm_fault_hold #(.INHIBIT_LEN(INHIBIT_LEN)) u_fault (
    .clk(clk), .rst(rst), .fault_trip(fault_trip),
    .period_start(period_start), .blk(blk), .inh_busy(inh_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_out <= 1'b0;
    else     gate_out <= mode_en && started && act_run && !blk &&
                         ({1'b0, slot_idx} < act_duty);
  end
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk
  import pwm_gate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode_en,
  input logic              fault_trip,
  input logic              gate_out,
  input logic              period_start,
  input logic [IDX_W-1:0]  slot_idx,
  input logic [DUTY_W-1:0] act_duty,
  input logic              blk,
  input logic              inh_busy
);
  AST_DUTY_CLAMPED: assert property (@(posedge clk) disable iff (rst) act_duty <= DUTY_W'(SLOTS)); // R2
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst) (act_duty == '0) |=> !gate_out); // R3
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) slot_idx < IDX_W'(SLOTS)); // R4
  AST_DUTY_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (rst) !period_start |=> $stable(act_duty)); // R5
  AST_RISE_AT_SLOT0: assert property (@(posedge clk) disable iff (rst) $rose(gate_out) |-> ($past(slot_idx) == '0)); // R6
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst) !mode_en |=> !gate_out); // R7
  AST_TRIP_FORCES_OFF: assert property (@(posedge clk) disable iff (rst) fault_trip |-> ##2 !gate_out); // R8
  AST_INHIBIT_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst) inh_busy |=> !gate_out); // R8
  AST_RESUME_AT_START: assert property (@(posedge clk) disable iff (rst) $fell(blk) |-> $past(period_start)); // R9
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .mode_en(mode_en), .fault_trip(fault_trip),
  .gate_out(gate_out), .period_start(period_start), .slot_idx(slot_idx),
  .act_duty(act_duty), .blk(blk), .inh_busy(inh_busy)
);

// File: tb/test_pwm_gate_ctrl.sv
module test_pwm_gate_ctrl;
  localparam int INH = 300;

  logic       clk = 1'b0;
  logic       rst, mode_en, wr_en, run_pin, run_ser, fault_trip;
  logic [6:0] duty_in;
  logic [2:0] freq_code;
  logic       gate_out;
  int         errs = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_gate_ctrl #(.SLOT_UNIT(1), .INHIBIT_LEN(INH)) i_pwm_gate_ctrl (
    .clk(clk), .rst(rst), .mode_en(mode_en), .wr_en(wr_en), .duty_in(duty_in),
    .freq_code(freq_code), .run_pin(run_pin), .run_ser(run_ser),
    .fault_trip(fault_trip), .gate_out(gate_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int d, input int c);
    wr_en = 1'b1; duty_in = 7'(d); freq_code = 3'(c);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Count samples until gate_out equals v.
  task automatic wait_until(input logic v, input int max, output int n);
    n = 0;
    while (gate_out !== v && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_high(input int len, output int n);
    n = 0;
    repeat (len) begin
      @(negedge clk);
      if (gate_out) n++;
    end
  endtask

  function automatic int exp_high(input int d, input int c);
    return ((d > 100) ? 100 : d) << c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n, hi, lo, tA, tB, ttrip, per, d, c;
    void'($urandom(32'd1234));
    rst = 1; mode_en = 0; wr_en = 0; run_pin = 0; run_ser = 0; fault_trip = 0;
    duty_in = 0; freq_code = 0;
    tick(4);
    chk(gate_out === 1'b0, "R10 reset low", gate_out, 0);
    rst = 0;
    tick(3);
    chk(gate_out === 1'b0, "R10 idle low", gate_out, 0);

    // R7 enable start, R1 and R4 basic
    wr(50, 0); run_ser = 1;
    mode_en = 1;
    tick(2);
    chk(gate_out === 1'b1, "R7 start high", gate_out, 1);
    wait_until(0, 400, n); hi = n;
    wait_until(1, 400, lo);
    chk(hi == 50, "R1 high width", hi, 50);
    chk(hi + lo == 100, "R4 period", hi + lo, 100);

    // R7 disable mid-pulse, then restart
    tick(3);
    mode_en = 0; tick(1);
    chk(gate_out === 1'b0, "R7 disable low", gate_out, 0);
    count_high(150, n);
    chk(n == 0, "R7 stays low", n, 0);
    mode_en = 1; tick(2);
    chk(gate_out === 1'b1, "R7 restart high", gate_out, 1);

    // R5 duty staged
    wr(30, 0); tick(210);
    wait_until(0, 400, n); wait_until(1, 400, n);
    tick(5); wr(70, 0);
    wait_until(0, 400, n);
    chk(6 + n == 30, "R5 duty held in period", 6 + n, 30);
    wait_until(1, 400, lo);
    wait_until(0, 400, hi);
    chk(hi == 70, "R5 duty applied next period", hi, 70);

    // R5 frequency staged
    wr(50, 0); tick(210);
    wait_until(0, 400, n); wait_until(1, 400, n);
    tick(5); wr(50, 1);
    wait_until(0, 400, n);
    chk(6 + n == 50, "R5 freq held high", 6 + n, 50);
    wait_until(1, 400, lo);
    chk(lo == 50, "R5 freq held low", lo, 50);
    wait_until(0, 400, hi); wait_until(1, 400, lo);
    chk(hi == 100 && lo == 100, "R5 freq applied", hi + lo, 200);

    // R2 clamp and R3 zero
    wr(101, 0); tick(310);
    count_high(250, n);
    chk(n == 250, "R2 duty 101 full on", n, 250);
    wr(127, 0); tick(110);
    count_high(250, n);
    chk(n == 250, "R2 duty 127 full on", n, 250);
    wr(0, 0); tick(110);
    count_high(250, n);
    chk(n == 0, "R3 duty zero low", n, 0);

    // R4 longest code
    wr(1, 7); tick(110);
    wait_until(0, 30000, n); wait_until(1, 30000, n);
    wait_until(0, 30000, hi); wait_until(1, 30000, lo);
    chk(hi == 128, "R1 code7 high", hi, 128);
    chk(hi + lo == 12800, "R4 code7 period", hi + lo, 12800);

    // R6 on/off at boundary
    wr(40, 0); tick(12900);
    wait_until(0, 400, n); wait_until(1, 400, n);
    tA = cyc;
    tick(2); run_ser = 0;
    wait_until(0, 400, n);
    chk(2 + n == 40, "R6 pulse completes after off", 2 + n, 40);
    count_high(250, n);
    chk(n == 0, "R6 off at boundary", n, 0);
    tick(37); run_pin = 1;
    wait_until(1, 400, n);
    tB = cyc;
    chk((tB - tA) % 100 == 0, "R6 on aligned to period", (tB - tA) % 100, 0);
    wait_until(0, 400, hi);
    chk(hi == 40, "R6 pin request drives", hi, 40);
    run_pin = 0; run_ser = 1;

    // R8 and R9 fault hold
    wr(50, 0); tick(210);
    wait_until(0, 400, n); wait_until(1, 400, n);
    tA = cyc;
    tick(10); fault_trip = 1; ttrip = cyc; tick(1); fault_trip = 0; tick(1);
    chk(gate_out === 1'b0, "R8 trip forces low", gate_out, 0);
    wait_until(1, 2000, n); tB = cyc;
    chk(tB - ttrip >= INH, "R8 inhibit length", tB - ttrip, INH);
    chk((tB - tA) % 100 == 0, "R9 resume at period start", (tB - tA) % 100, 0);
    tick(15); fault_trip = 1; tick(1); fault_trip = 0;
    tick(200); fault_trip = 1; ttrip = cyc; tick(1); fault_trip = 0;
    wait_until(1, 2000, n); tB = cyc;
    chk(tB - ttrip >= INH, "R8 retrip restarts", tB - ttrip, INH);
    chk((tB - tA) % 100 == 0, "R9 resume after retrip", (tB - tA) % 100, 0);

    // R1 R2 R3 R4 random
    per = 100;
    for (int i = 0; i < 12; i++) begin
      d = int'($urandom % 128); c = int'($urandom % 2);
      wr(d, c); tick(per + 5); per = 100 << c;
      if (exp_high(d, c) == 0) begin
        count_high(2 * per, n);
        chk(n == 0, "R3 random zero", n, 0);
      end else if (exp_high(d, c) == per) begin
        count_high(2 * per, n);
        chk(n == 2 * per, "R2 random full", n, 2 * per);
      end else begin
        wait_until(0, 3 * per, n); wait_until(1, 3 * per, n);
        wait_until(0, 3 * per, hi); wait_until(1, 3 * per, lo);
        chk(hi == exp_high(d, c), "R1 random width", hi, exp_high(d, c));
        chk(hi + lo == per, "R4 random period", hi + lo, per);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule